// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block owns the direction pin of an external half-duplex RS-485 line driver attached to a UART. When the direction function is enabled, a write into the transmit queue switches the driver to transmit. The pin stays in the transmit state while characters are still queued or shifting. The driver is handed back to the bus only after the stop bit of the final queued character has gone out, plus a programmable turnaround hold-off. The hold-off is counted in bit periods, and each bit period is sixteen ticks of the oversampling baud reference.

The transmitter, the queue and the baud generator sit outside this block and appear only as ports. `char_done` pulses for one cycle when a stop bit completes. `queue_empty` tells whether that character was the last one queued. Three configuration inputs set the behaviour: enable, pin polarity and hold-off length.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high, `dir_pin` is driven on the next edge to the released level for the current `dir_invert` (1 when `dir_invert`=0, 0 when `dir_invert`=1), and any running hold-off is discarded.
- R2: While `dir_en` is 0, `dir_pin` is at the released level one cycle later, whatever `tx_wr`, `char_done` or `baud16_tick` do.
- R3: With `dir_en`=1, a cycle with `tx_wr`=1 makes `dir_pin` take the asserted level from the following clock edge.
- R4: Polarity: with `dir_invert`=0 the asserted level is 0 and the released level is 1; with `dir_invert`=1 both levels are swapped.
- R5: A `char_done` pulse while `queue_empty`=0 does not release the pin.
- R6: After `char_done` with `queue_empty`=1 and `hold_bits`=N>0, the pin stays asserted for exactly 16*N cycles with `baud16_tick`=1 and is released at the edge that samples the last of them.
- R7: With `hold_bits`=0, the pin is released at the edge that samples the final `char_done`.
- R8: A `tx_wr` during the hold-off cancels it with no release glitch; the pin stays asserted until a later final `char_done`, which starts a full new hold-off.
- R9: The largest setting, `hold_bits`=255, holds the pin for 4080 ticks.
- R10: Cycles without `baud16_tick` do not advance the hold-off, and ticks outside a hold-off have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Character written into the transmit queue this cycle |
| char_done | input | 1 | One-cycle pulse: a stop bit has just completed |
| queue_empty | input | 1 | No character queued behind the one completing |
| baud16_tick | input | 1 | Baud reference tick, 16 per bit period |
| dir_en | input | 1 | Direction function enable |
| dir_invert | input | 1 | Swap asserted and released pin levels |
| hold_bits | input | DLY_W | Turnaround hold-off in bit periods, 0 to 255 |
| dir_pin | output | 1 | Line-driver direction output (registered) |

## Verification
If the controller wrongly believed it was idle, the pin would flip to the released level on the very next edge while data was still on the wire. That is visible in one cycle after a queued `char_done` or during a hold-off. A stale or miscounted hold-off counter shows up only at the end of the turnaround window, as a release that comes some ticks early or late. For that reason the bench counts ticks exactly through windows with sparse ticks and through the full 255-bit window. A bit timer that failed to clear after a cancelled hold-off would shorten the next window, which the cancel-then-restart sequence exposes.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_DRIVE = 2'd1,
        DIR_HOLD  = 2'd2
    } dir_state_e;

    // Pin level for a given activity and polarity choice.
    function automatic logic pin_level(input logic active, input logic invert);
        return active ? invert : ~invert;
    endfunction

    function automatic logic is_active(input dir_state_e s);
        return s != DIR_IDLE;
    endfunction

endpackage

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       wr,
    input  logic       char_done,
    input  logic       queue_empty,
    input  logic       delay_zero,
    input  logic       hold_expire,
    output dir_state_e state_q,
    output dir_state_e state_d,
    output logic       load_hold
);

    always_comb begin
        state_d   = state_q;
        load_hold = 1'b0;
        if (!en) begin
            state_d = DIR_IDLE;
        end else begin
            unique case (state_q)
                DIR_IDLE: begin
                    if (wr) state_d = DIR_DRIVE;
                end
                DIR_DRIVE: begin
                    if (!wr && char_done && queue_empty) begin
                        if (delay_zero) begin
                            state_d = DIR_IDLE;
                        end else begin
                            state_d   = DIR_HOLD;
                            load_hold = 1'b1;
                        end
                    end
                end
                DIR_HOLD: begin
                    if (wr)               state_d = DIR_DRIVE;
                    else if (hold_expire) state_d = DIR_IDLE;
                end
                default: state_d = DIR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/rs485_bit_timer.sv
module rs485_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic bit_end
);

    localparam int SUB_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
    localparam bit POW2 = ((OVERSAMPLE & (OVERSAMPLE - 1)) == 0);

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_inc;

    assign bit_end = run && tick && (sub_q == SUB_LAST);

    generate
        if (POW2) begin : g_wrap_free
            assign sub_inc = sub_q + 1'b1;
        end else begin : g_wrap_cmp
            assign sub_inc = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) sub_q <= '0;
        else if (tick)   sub_q <= sub_inc;
    end

endmodule

// File: rtl/rs485_holdoff.sv
module rs485_holdoff #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign last = dec && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (load)              cnt_q <= load_val;
        else if (dec && cnt_q != 0) cnt_q <= cnt_q - ONE;
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W      = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_wr,
    input  logic             char_done,
    input  logic             queue_empty,
    input  logic             baud16_tick,
    input  logic             dir_en,
    input  logic             dir_invert,
    input  logic [DLY_W-1:0] hold_bits,
    output logic             dir_pin
);

    dir_state_e state_q;
    dir_state_e state_d;
    logic       load_hold;
    logic       bit_end;
    logic       hold_expire;
    logic       dir_q;

    rs485_dir_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en          (dir_en),
        .wr          (tx_wr),
        .char_done   (char_done),
        .queue_empty (queue_empty),
        .delay_zero  (hold_bits == '0),
        .hold_expire (hold_expire),
        .state_q     (state_q),
        .state_d     (state_d),
        .load_hold   (load_hold)
    );

    rs485_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_bit (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == DIR_HOLD),
        .tick    (baud16_tick),
        .bit_end (bit_end)
    );

    rs485_holdoff #(.CNT_W(DLY_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (load_hold),
        .load_val (hold_bits),
        .dec      (bit_end),
        .last     (hold_expire)
    );

    // Registered pin: no combinational path from strobes to the pad.
    always_ff @(posedge clk) begin
        if (rst) dir_q <= pin_level(1'b0, dir_invert);
        else     dir_q <= pin_level(is_active(state_d), dir_invert);
    end

    assign dir_pin = dir_q;

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk
    import rs485_dir_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_wr,
    input logic             char_done,
    input logic             queue_empty,
    input logic             baud16_tick,
    input logic             dir_en,
    input logic             dir_invert,
    input logic [DLY_W-1:0] hold_bits,
    input logic             dir_pin,
    input dir_state_e       state_q
);

    // R1: reset drives the released level for the polarity in force
    a_r1_reset_level: assert property (@(posedge clk)
        rst |=> dir_pin == !$past(dir_invert));

    // R2
    a_r2_disabled_released: assert property (@(posedge clk) disable iff (rst)
        !dir_en |=> dir_pin == !$past(dir_invert));

    // R3
    a_r3_write_asserts: assert property (@(posedge clk) disable iff (rst)
        dir_en && tx_wr |=> dir_pin == $past(dir_invert));

    // R5
    a_r5_hold_while_queued: assert property (@(posedge clk) disable iff (rst)
        dir_en && state_q == DIR_DRIVE && !(char_done && queue_empty)
        |=> dir_pin == $past(dir_invert));

    // R6
    a_r6_hold_entry: assert property (@(posedge clk) disable iff (rst)
        dir_en && state_q == DIR_DRIVE && char_done && queue_empty && !tx_wr
        && hold_bits != '0 |=> state_q == DIR_HOLD);

    // R7
    a_r7_zero_delay: assert property (@(posedge clk) disable iff (rst)
        dir_en && state_q == DIR_DRIVE && char_done && queue_empty && !tx_wr
        && hold_bits == '0 |=> dir_pin == !$past(dir_invert));

    // R8
    a_r8_write_cancels: assert property (@(posedge clk) disable iff (rst)
        dir_en && state_q == DIR_HOLD && tx_wr
        |=> state_q == DIR_DRIVE && dir_pin == $past(dir_invert));

    // R10
    a_r10_no_tick_no_progress: assert property (@(posedge clk) disable iff (rst)
        dir_en && state_q == DIR_HOLD && !tx_wr && !baud16_tick
        |=> state_q == DIR_HOLD);

endmodule

bind rs485_dir_ctrl rs485_dir_chk #(.DLY_W(DLY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_wr       (tx_wr),
    .char_done   (char_done),
    .queue_empty (queue_empty),
    .baud16_tick (baud16_tick),
    .dir_en      (dir_en),
    .dir_invert  (dir_invert),
    .hold_bits   (hold_bits),
    .dir_pin     (dir_pin),
    .state_q     (state_q)
);

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DLY_W      = 8;
    localparam int OVS        = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tx_wr = 1'b0;
    logic             char_done = 1'b0;
    logic             queue_empty = 1'b1;
    logic             baud16_tick = 1'b0;
    logic             dir_en = 1'b1;
    logic             dir_invert = 1'b1;
    logic [DLY_W-1:0] hold_bits = 8'd2;
    logic             dir_pin;

    int   checks = 0;
    int   errors = 0;
    int   occ = 0;          // characters queued or shifting
    int   m_state = 0;      // 0 idle, 1 drive, 2 hold
    int   m_left = 0;       // ticks left in hold-off
    logic m_dir = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_dir_ctrl #(.DLY_W(DLY_W), .OVERSAMPLE(OVS)) u_dut (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .char_done(char_done),
        .queue_empty(queue_empty), .baud16_tick(baud16_tick),
        .dir_en(dir_en), .dir_invert(dir_invert), .hold_bits(hold_bits),
        .dir_pin(dir_pin)
    );

    function automatic logic exp_level(input logic active, input logic inv);
        return active ? inv : ~inv;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dir_pin=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_state = 0; m_left = 0;
        end else if (!dir_en) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: if (tx_wr) m_state = 1;
                1: if (!tx_wr && char_done && queue_empty) begin
                       if (hold_bits == 0) m_state = 0;
                       else begin m_state = 2; m_left = int'(hold_bits) * OVS; end
                   end
                default: if (tx_wr) m_state = 1;
                         else if (baud16_tick) begin
                             m_left--;
                             if (m_left == 0) m_state = 0;
                         end
            endcase
        end
        m_dir = exp_level(m_state != 0, dir_invert);
    endtask

    task automatic step(input bit wr, input bit done, input bit tick, input string tag);
        tx_wr       = wr;
        char_done   = done && (occ > 0);
        queue_empty = (occ <= 1);
        baud16_tick = tick;
        model_edge();
        @(posedge clk);
        if (tx_wr) occ++;
        if (char_done) occ--;
        @(negedge clk);
        check(tag, dir_pin, m_dir);
    endtask

    task automatic drain(input string tag);
        while (occ > 0) step(1'b0, 1'b1, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset with inverted polarity
        repeat (3) step(1'b0, 1'b0, 1'b0, "R1");
        check("R1", dir_pin, 1'b0);
        dir_invert = 1'b0;
        step(1'b0, 1'b0, 1'b0, "R1");
        check("R1", dir_pin, 1'b1);
        rst = 1'b0;

        // R3/R4: first write asserts low
        step(1'b1, 1'b0, 1'b0, "R3");
        check("R4", dir_pin, 1'b0);
        // R5: non-final completion keeps the pin asserted
        step(1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b1, "R5");
        check("R5", dir_pin, 1'b0);
        // R6/R10: final completion, hold of 2 bits with sparse ticks
        step(1'b0, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 2*OVS - 1; i++) begin
            step(1'b0, 1'b0, 1'b1, "R6");
            step(1'b0, 1'b0, 1'b0, "R10");
        end
        check("R6", dir_pin, 1'b0);
        step(1'b0, 1'b0, 1'b1, "R6");
        check("R6", dir_pin, 1'b1);
        repeat (5) step(1'b0, 1'b0, 1'b1, "R10");
        check("R10", dir_pin, 1'b1);

        // R8: write during hold-off cancels, later completion restarts
        step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R8");
        repeat (20) step(1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b1, "R8");
        check("R8", dir_pin, 1'b0);
        repeat (40) step(1'b0, 1'b0, 1'b1, "R8");
        check("R8", dir_pin, 1'b0);
        step(1'b0, 1'b1, 1'b0, "R8");
        repeat (2*OVS - 1) step(1'b0, 1'b0, 1'b1, "R8");
        check("R8", dir_pin, 1'b0);
        step(1'b0, 1'b0, 1'b1, "R8");
        check("R8", dir_pin, 1'b1);

        // R7: zero hold-off
        hold_bits = 8'd0;
        step(1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b0, "R7");
        check("R7", dir_pin, 1'b1);

        // R4: inverted polarity levels
        dir_invert = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R4");
        check("R4", dir_pin, 1'b0);
        step(1'b1, 1'b0, 1'b0, "R4");
        check("R4", dir_pin, 1'b1);
        step(1'b0, 1'b1, 1'b0, "R4");
        check("R4", dir_pin, 1'b0);

        // R2: disabled, writes ignored; disabling mid-transmit releases
        step(1'b1, 1'b0, 1'b0, "R2");
        dir_en = 1'b0;
        step(1'b0, 1'b0, 1'b0, "R2");
        check("R2", dir_pin, 1'b0);
        step(1'b1, 1'b0, 1'b1, "R2");
        check("R2", dir_pin, 1'b0);
        drain("R2");
        check("R2", dir_pin, 1'b0);
        dir_en = 1'b1;

        // R1: reset in the middle of a transmission
        step(1'b1, 1'b0, 1'b0, "R1");
        check("R1", dir_pin, 1'b1);
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R1");
        check("R1", dir_pin, 1'b0);
        rst = 1'b0;
        drain("R1");

        // R9: maximum hold-off
        dir_invert = 1'b0;
        hold_bits  = 8'd255;
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, "R9");
        repeat (255*OVS - 1) step(1'b0, 1'b0, 1'b1, "R9");
        check("R9", dir_pin, 1'b0);
        step(1'b0, 1'b0, 1'b1, "R9");
        check("R9", dir_pin, 1'b1);

        // Random phase against the model
        void'($urandom(32'h5EED_0485));
        hold_bits = 8'd1;
        for (int n = 0; n < 20000; n++) begin
            bit    wr;
            bit    dn;
            bit    tk;
            string tag;
            wr = (($urandom % 8) == 0) && (occ < 4);
            dn = (($urandom % 6) == 0);
            tk = (($urandom % 2) == 0);
            if (($urandom % 200) == 0) dir_en = ~dir_en;
            if (($urandom % 300) == 0) dir_invert = ~dir_invert;
            if (($urandom % 50) == 0)  hold_bits = 8'($urandom % 5);
            if (!dir_en)           tag = "R2";
            else if (m_state == 2) tag = "R6";
            else if (m_state == 1) tag = "R5";
            else                   tag = "R3";
            step(wr, dn, tk, tag);
        end

        finish_run();
    end

endmodule